// File: doc/BRIEF.md
# Linear Sensor Scan Sequencer

This block models the switch-control logic of one section of a linear photodiode array as a clocked digital sequencer. A start pulse sampled high on a rising pixel-clock edge launches a scan. From that edge on, the block names one pixel per clock on an index bus with a valid flag. The valid flag stands for the analog output being driven; when it is low the output is in its high-impedance state. During the same scan the block keeps a shared integrator reset asserted for a fixed number of clocks. It also pulses a per-pixel mask that tells each pixel when to reconnect its sampling capacitor to its integrator. A separate hold input produces a global hold strobe on its rising level.

Near the end of the scan the block raises a serial-out token. That token can drive the start input of a second section, which chains the two sections into one longer array. A start pulse that comes before the previous scan has run its full length is dropped, and a one-clock protocol-error pulse is raised instead. Analog behaviour is not modelled. The pixel count and the reset window length are parameters.

Top module: `lss_scan_seq`

## Requirements
- R1: After reset the block is idle: `pix_vld_o`, `so_o`, `integ_rst_o`, `hold_stb_o` and `proto_err_o` are low, `rcn_o` is all zeros and `pix_idx_o` is zero.
- R2: When `si_i` is sampled high on a rising edge while the block is idle, pixel 1 is selected after that edge (`pix_vld_o` = 1, `pix_idx_o` = 0). Each following edge advances `pix_idx_o` by one, so pixel p appears as index p-1. While `pix_vld_o` is low, `pix_idx_o` is 0.
- R3: `integ_rst_o` goes high after the edge that accepts a start pulse. It stays high for RST_CLKS clocks in total and falls on edge RST_CLKS+1, counting the accepting edge as edge 1.
- R4: `hold_stb_o` is high for exactly the one clock after an edge at which `hold_i` is sampled high, provided it was sampled low at the edge before. It does not depend on `si_i`.
- R5: `rcn_o` bit p-1 belongs to pixel p. After edge RST_CLKS+1, bits 0 to RST_CLKS-1 pulse together for one clock. After edge p+1, for p > RST_CLKS, only bit p-1 is high. In every other clock `rcn_o` is zero.
- R6: `so_o` is high for the single clock after edge N. On edge N+1, `so_o` and `pix_vld_o` both return low.
- R7: A start pulse sampled on edge N+2 or later after the previous accepted one is accepted. Edge N+2 is the earliest such edge, the clock right after the scan ends. Accepting it restarts the scan at pixel 1 with no protocol error.
- R8: A start pulse sampled on edges 2 to N+1 of a running scan is ignored: the scan continues unchanged, and `proto_err_o` is high for the one clock after that edge.
- R9: When `so_o` of one instance drives `si_i` of a second, the second instance's `so_o` is high for the single clock after edge 2N, counted from the first instance's accepting edge, and low again after edge 2N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| si_i | input | 1 | Scan start pulse, one clock wide |
| hold_i | input | 1 | Hold request; usually tied to `si_i` |
| pix_vld_o | output | 1 | Analog output driven (low = high impedance) |
| pix_idx_o | output | $clog2(N) | Index of the pixel being read out (pixel p = p-1) |
| hold_stb_o | output | 1 | Global sampler disconnect strobe |
| integ_rst_o | output | 1 | Global integrator reset level |
| rcn_o | output | N | Per-pixel sampler reconnect pulse |
| so_o | output | 1 | Serial-out token for chaining |
| proto_err_o | output | 1 | Start pulse arrived too early and was dropped |

## Verification
Every output depends on values sampled at one rising edge and is due in the clock that follows it. A start pulse accepted at edge 1 therefore shows pixel k after edge k, with the reset falling after edge RST_CLKS+1, the token after edge N and the release after edge N+1. The hold strobe and the error pulse each appear one edge after their cause. The bench updates a per-section phase model at each edge, using the inputs held across that edge. It then compares all outputs a quarter period later, so each expected value sits in the same clock as the result it predicts. For the chained second section, the model takes as input the first section's token as it was before the edge. This reproduces the one-clock handoff.

// File: rtl/lss_pkg.sv
package lss_pkg;
   // Width of the scan phase counter: holds 0 (idle) through n+1.
   function automatic int phase_width(input int n);
      return $clog2(n + 2);
   endfunction
   // Width of a pixel index for n pixels.
   function automatic int index_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lss_phase_ctr.sv
module lss_phase_ctr
   import lss_pkg::*;
#(
   parameter int N  = 768,
   parameter int CW = phase_width(N)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          si_i,
   output logic [CW-1:0] phase_o,
   output logic          err_o
);
   localparam logic [CW-1:0] PH_IDLE = '0;
   localparam logic [CW-1:0] PH_ONE  = CW'(1);
   localparam logic [CW-1:0] PH_LAST = CW'(N + 1);

   logic can_start;
   assign can_start = (phase_o == PH_IDLE) || (phase_o == PH_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_o <= PH_IDLE;
         err_o   <= 1'b0;
      end else begin
         err_o <= si_i && !can_start;
         if (si_i && can_start) begin
            phase_o <= PH_ONE;
         end else if (phase_o == PH_LAST) begin
            phase_o <= PH_IDLE;
         end else if (phase_o != PH_IDLE) begin
            phase_o <= phase_o + PH_ONE;
         end
      end
   end

   // An early start never restarts the scan at pixel 1 (R8).
   assert_err_scan_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (phase_o != PH_ONE));

   // The counter only ever leaves idle through phase 1 (R2).
   assert_start_from_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(phase_o) == PH_IDLE) && (phase_o != PH_IDLE) |-> (phase_o == PH_ONE));
endmodule

// File: rtl/lss_phase_decode.sv
module lss_phase_decode
   import lss_pkg::*;
#(
   parameter int N         = 768,
   parameter int RST_CLKS  = 18,
   parameter int CW        = phase_width(N),
   parameter int IW        = index_width(N)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] phase_i,
   output logic          vld_o,
   output logic [IW-1:0] idx_o,
   output logic          integ_rst_o,
   output logic          so_o,
   output logic          release_o
);
   localparam logic [CW-1:0] PH_ONE = CW'(1);
   localparam logic [CW-1:0] PH_N   = CW'(N);
   localparam logic [CW-1:0] PH_RST = CW'(RST_CLKS);
   localparam logic [CW-1:0] PH_REL = CW'(RST_CLKS + 1);

   logic [CW-1:0] ph_minus_one;
   assign ph_minus_one = phase_i - PH_ONE;

   always_comb begin
      vld_o       = (phase_i >= PH_ONE) && (phase_i <= PH_N);
      idx_o       = vld_o ? ph_minus_one[IW-1:0] : '0;
      integ_rst_o = (phase_i >= PH_ONE) && (phase_i <= PH_RST);
      so_o        = (phase_i == PH_N);
      release_o   = (phase_i == PH_REL);
   end

   // Consecutive valid clocks step the index by exactly one pixel (R2).
   assert_idx_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o && $past(vld_o) && (idx_o != '0) |-> (idx_o == $past(idx_o) + IW'(1)));

   // The release clock always follows the reset window (R3).
   assert_release_after_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      release_o |-> $past(integ_rst_o));
endmodule

// File: rtl/lss_reconnect.sv
module lss_reconnect
   import lss_pkg::*;
#(
   parameter int N        = 768,
   parameter int RST_CLKS = 18,
   parameter int CW       = phase_width(N)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] phase_i,
   input  logic          release_i,
   output logic [N-1:0]  rcn_o
);
   for (genvar g = 0; g < N; g++) begin : g_pix
      if (g < RST_CLKS) begin : g_grp
         // Pixels read while the reset is active reconnect together.
         assign rcn_o[g] = release_i;
      end else begin : g_seq
         // Later pixels reconnect one clock after their own readout.
         localparam logic [CW-1:0] PH_MINE = CW'(g + 2);
         assign rcn_o[g] = (phase_i == PH_MINE);
      end
   end

   // Outside the group release at most one pixel reconnects (R5).
   assert_rcn_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !release_i |-> $onehot0(rcn_o));
endmodule

// File: rtl/lss_scan_seq.sv
module lss_scan_seq
   import lss_pkg::*;
#(
   parameter int N        = 768,
   parameter int RST_CLKS = 18,
   parameter int IW       = index_width(N)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          si_i,
   input  logic          hold_i,
   output logic          pix_vld_o,
   output logic [IW-1:0] pix_idx_o,
   output logic          hold_stb_o,
   output logic          integ_rst_o,
   output logic [N-1:0]  rcn_o,
   output logic          so_o,
   output logic          proto_err_o
);
   localparam int CW = phase_width(N);

   if (RST_CLKS < 1) begin : g_bad_rst
      $error("RST_CLKS must be at least 1");
   end
   if (RST_CLKS + 1 >= N) begin : g_bad_n
      $error("N must exceed RST_CLKS + 1");
   end
   if (IW < index_width(N)) begin : g_bad_iw
      $error("IW too narrow for N");
   end

   logic [CW-1:0]           phase;
   logic                    release_w;
   logic [index_width(N)-1:0] idx_w;
   logic                    hold_q;

   lss_phase_ctr #(.N(N), .CW(CW)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .si_i    (si_i),
      .phase_o (phase),
      .err_o   (proto_err_o)
   );

   lss_phase_decode #(.N(N), .RST_CLKS(RST_CLKS), .CW(CW), .IW(index_width(N))) u_dec (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .phase_i     (phase),
      .vld_o       (pix_vld_o),
      .idx_o       (idx_w),
      .integ_rst_o (integ_rst_o),
      .so_o        (so_o),
      .release_o   (release_w)
   );

   assign pix_idx_o = IW'(idx_w);

   lss_reconnect #(.N(N), .RST_CLKS(RST_CLKS), .CW(CW)) u_rcn (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .phase_i   (phase),
      .release_i (release_w),
      .rcn_o     (rcn_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q     <= 1'b0;
         hold_stb_o <= 1'b0;
      end else begin
         hold_q     <= hold_i;
         hold_stb_o <= hold_i && !hold_q;
      end
   end

   // The token is followed by the end of the readout (R6).
   assert_so_then_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      so_o |=> (!so_o && !pix_vld_o));

   // Release of the integrators frees exactly the reset-window group (R5).
   assert_group_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(integ_rst_o) |-> ($countones(rcn_o) == RST_CLKS));

   // The reset window opens together with pixel 1 (R3).
   assert_reset_with_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(integ_rst_o) |-> (pix_vld_o && (pix_idx_o == '0)));

   // The hold strobe is a single clock wide (R4).
   assert_hold_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_stb_o |=> !hold_stb_o);
endmodule

// File: tb/sim_lss_scan_seq.sv
module sim_lss_scan_seq;
   localparam int  P   = 10;
   localparam int  N   = 30;
   localparam int  RST = 18;
   localparam int  IW  = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic si = 1'b0, hold = 1'b0;

   logic          vld0, hstb0, irst0, so0, err0;
   logic [IW-1:0] idx0;
   logic [N-1:0]  rcn0;
   logic          vld1, hstb1, irst1, so1, err1;
   logic [IW-1:0] idx1;
   logic [N-1:0]  rcn1;

   always #(P/2) clk = ~clk;

   lss_scan_seq #(.N(N), .RST_CLKS(RST)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .si_i(si), .hold_i(hold),
      .pix_vld_o(vld0), .pix_idx_o(idx0), .hold_stb_o(hstb0), .integ_rst_o(irst0),
      .rcn_o(rcn0), .so_o(so0), .proto_err_o(err0));

   lss_scan_seq #(.N(N), .RST_CLKS(RST)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .si_i(so0), .hold_i(so0),
      .pix_vld_o(vld1), .pix_idx_o(idx1), .hold_stb_o(hstb1), .integ_rst_o(irst1),
      .rcn_o(rcn1), .so_o(so1), .proto_err_o(err1));

   int tests = 0, fails = 0;
   int ph0 = 0, ph1 = 0;
   bit hprev = 0, hstb_e = 0, err_e = 0;

   function automatic bit f_vld(int ph);   return ph >= 1 && ph <= N;     endfunction
   function automatic int f_idx(int ph);   return f_vld(ph) ? ph - 1 : 0; endfunction
   function automatic bit f_irst(int ph);  return ph >= 1 && ph <= RST;   endfunction
   function automatic bit f_so(int ph);    return ph == N;                endfunction
   function automatic logic [63:0] f_rcn(int ph);
      if (ph == RST + 1) return (64'd1 << RST) - 64'd1;
      if (ph > RST + 1 && ph <= N + 1) return 64'd1 << (ph - 2);
      return 64'd0;
   endfunction
   function automatic int f_next(int ph, bit s, output bit e);
      e = 0;
      if (s && (ph == 0 || ph == N + 1)) return 1;
      if (s) e = 1;
      if (ph == N + 1) return 0;
      if (ph != 0) return ph + 1;
      return 0;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2", "vld0", 64'(vld0), 64'(f_vld(ph0)));
      chk("R2", "idx0", 64'(idx0), 64'(f_idx(ph0)));
      chk("R3", "irst0", 64'(irst0), 64'(f_irst(ph0)));
      chk("R4", "hstb0", 64'(hstb0), 64'(hstb_e));
      chk("R5", "rcn0", 64'(rcn0), f_rcn(ph0));
      chk("R6", "so0", 64'(so0), 64'(f_so(ph0)));
      chk("R8", "err0", 64'(err0), 64'(err_e));
      chk("R9", "so1", 64'(so1), 64'(f_so(ph1)));
      chk("R9", "vld1", 64'(vld1), 64'(f_vld(ph1)));
   endtask

   // One clock: drive at falling edge, model at rising edge, check after it.
   task automatic step(bit s, bit h);
      bit e0, e1, so_prev;
      @(negedge clk);
      si = s; hold = h;
      @(posedge clk);
      so_prev = f_so(ph0);
      ph0 = f_next(ph0, s, e0);
      ph1 = f_next(ph1, so_prev, e1);
      err_e = e0;
      hstb_e = h && !hprev;
      hprev = h;
      #(P/4);
      check_all();
   endtask

   initial begin
      #(P * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1412));
      #(P * 3);
      // R1: idle state held after reset
      chk("R1", "vld", 64'(vld0), 0);
      chk("R1", "so", 64'(so0), 0);
      chk("R1", "irst", 64'(irst0), 0);
      chk("R1", "rcn", 64'(rcn0), 0);
      chk("R1", "err/hstb/idx", {err0, hstb0, 62'(idx0)}, 0);
      @(negedge clk); rst_n = 1'b1;
      step(0, 0); step(0, 0);
      // Full scan with start and hold tied
      step(1, 1);
      for (int i = 0; i < N + 4; i++) step(0, 0);
      // Early start inside a scan (R8)
      step(1, 1);
      for (int i = 0; i < 4; i++) step(0, 0);
      step(1, 0);
      chk("R8", "scan kept idx", 64'(idx0), 64'd5);
      for (int i = 0; i < N; i++) step(0, 0);
      // Back-to-back start on the first legal edge (R7)
      step(1, 1);
      for (int i = 0; i < N; i++) step(0, 0);
      step(1, 1);
      chk("R7", "restart vld", 64'(vld0), 1);
      chk("R7", "restart idx", 64'(idx0), 0);
      chk("R7", "restart err", 64'(err0), 0);
      for (int i = 0; i < 2 * N + 4; i++) step(0, 0);
      // Hold alone, held several clocks (R4)
      step(0, 1); step(0, 1); step(0, 1); step(0, 0);
      // Random mix
      for (int i = 0; i < 4000; i++) begin
         bit s = ($urandom % 25) == 0;
         bit h = s ? 1'b1 : (($urandom % 40) == 0);
         step(s, h);
      end
      for (int i = 0; i < 2 * N + 4; i++) step(0, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule